// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a small synchronous counter with a single rising-edge clock. A parameter selects its counting sequence when it is built. It can run as a decade counter over 0 to 9, with 8-4-2-1 weighting. It can also run as a plain binary counter that wraps at 2^WIDTH. An active-low load input copies a data word into the state. Two active-low enables allow counting only when both are low, and a direction input chooses increment or decrement.

A combinational, active-low terminal-count output marks the end of the sequence in the current direction. Only the trickle enable gates it; the parallel enable has no effect on it. Several stages can therefore be chained for carry lookahead. Each stage's terminal count drives the next stage's trickle enable. All stages share the parallel enable, the load input and the direction input, so a multi-digit counter advances as one unit.

In decade mode the six codes above nine are illegal. They can be reached through a load. From any of them the counter returns to the legal range within two counts. A synchronous active-high reset clears the state.

Top module: `updn_counter`

## Requirements
- R1: When `rst` is high on a rising edge, `cnt` becomes 0 on that edge, whatever every other input is doing.
- R2: When `pload_n` is low (and `rst` low), `d` is copied into `cnt` on the next rising edge, whatever `ena_p_n`, `ena_t_n` and `dir_up` are.
- R3: With `pload_n` high, `cnt` holds its value across a rising edge if either `ena_p_n` or `ena_t_n` is high.
- R4: With `pload_n` high and both enables low, `cnt` goes up by one on a rising edge when `dir_up` is 1 and down by one when `dir_up` is 0.
- R5: Wrap-around: in binary mode counting up goes from 2^WIDTH-1 to 0 and counting down goes from 0 to 2^WIDTH-1. In decade mode counting up goes from 9 to 0 and counting down goes from 0 to 9.
- R6: `term_n` is 0 exactly when `ena_t_n` is 0 and `cnt` is at the end value for the direction: 0 when `dir_up` is 0, and 9 (decade) or 2^WIDTH-1 (binary) when `dir_up` is 1. Otherwise it is 1. `ena_p_n` has no effect on it.
- R7: In decade mode, with `dir_up` 1 and `ena_t_n` 0, `term_n` is also 0 in states 11, 13 and 15, and stays 1 in states 10, 12 and 14.
- R8: In decade mode, one count up moves an illegal state as follows: 10 to 11, 11 to 6, 12 to 13, 13 to 4, 14 to 15, 15 to 2. One count down moves any illegal state to 9. Every illegal state therefore reaches 0..9 within two counts.
- R9: When two decade stages are chained (lower `term_n` drives upper `ena_t_n`, with `pload_n`, `ena_p_n` and `dir_up` in common), the pair counts as a two-digit decimal number up and down across the digit boundary. The upper stage holds while the lower stage is not at its end value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears the state |
| pload_n | input | 1 | Active-low load enable, overrides counting |
| d | input | WIDTH | Data loaded into the state |
| ena_p_n | input | 1 | Active-low count enable, does not gate the terminal count |
| ena_t_n | input | 1 | Active-low count enable, also gates the terminal count |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| cnt | output | WIDTH | Current counter state |
| term_n | output | 1 | Active-low terminal count, combinational |

## Verification
Some rules are checked by assertions on every clock. These are: load priority, hold when either enable is high, a high trickle enable forcing the terminal count high, the binary wrap, and the decade recovery steps out of illegal states. The bench scenarios cover the rest. These are: the exact terminal-count value in every direction and mode with the parallel enable toggled, the full illegal-state map, and a two-digit cascade crossing 19/20 in both directions. None of these can be seen from one stage on a single edge.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic {
        MODE_BINARY = 1'b0,
        MODE_DECADE = 1'b1
    } count_mode_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_UP   = 2'd1,
        OP_DOWN = 2'd2,
        OP_LOAD = 2'd3
    } count_op_e;

    typedef struct packed {
        count_op_e op;
        logic      tc_gate;
    } ctrl_t;

    localparam logic [3:0] BCD_LAST = 4'd9;

    // decade increment, including the illegal-code steering
    function automatic logic [3:0] bcd_inc(input logic [3:0] v);
        logic [3:0] r;
        case (v)
            4'd9:    r = 4'd0;
            4'd11:   r = 4'd6;
            4'd13:   r = 4'd4;
            4'd15:   r = 4'd2;
            default: r = v + 4'd1;
        endcase
        return r;
    endfunction

    // decade decrement; all illegal codes fall back to nine
    function automatic logic [3:0] bcd_dec(input logic [3:0] v);
        logic [3:0] r;
        if (v == 4'd0 || v > BCD_LAST)
            r = BCD_LAST;
        else
            r = v - 4'd1;
        return r;
    endfunction

    function automatic logic bcd_odd_illegal(input logic [3:0] v);
        return (v > BCD_LAST) && v[0];
    endfunction

endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
    import updn_pkg::*;
(
    input  logic  pload_n,
    input  logic  ena_p_n,
    input  logic  ena_t_n,
    input  logic  dir_up,
    output ctrl_t ctrl
);

    always_comb begin
        ctrl.tc_gate = ~ena_t_n;
        if (!pload_n)
            ctrl.op = OP_LOAD;
        else if (ena_p_n || ena_t_n)
            ctrl.op = OP_HOLD;
        else if (dir_up)
            ctrl.op = OP_UP;
        else
            ctrl.op = OP_DOWN;
    end

endmodule

// File: rtl/updn_next.sv
module updn_next
    import updn_pkg::*;
#(
    parameter int          WIDTH = 4,
    parameter count_mode_e MODE  = MODE_BINARY
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] d,
    input  count_op_e        op,
    output logic [WIDTH-1:0] nxt
);

    logic [WIDTH-1:0] step_up;
    logic [WIDTH-1:0] step_dn;

    generate
        if (MODE == MODE_DECADE) begin : g_dec
            always_comb begin
                step_up = WIDTH'(bcd_inc(cur[3:0]));
                step_dn = WIDTH'(bcd_dec(cur[3:0]));
            end
        end else begin : g_bin
            always_comb begin
                step_up = cur + WIDTH'(1);
                step_dn = cur - WIDTH'(1);
            end
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = d;
            OP_UP:   nxt = step_up;
            OP_DOWN: nxt = step_dn;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/updn_term.sv
module updn_term
    import updn_pkg::*;
#(
    parameter int          WIDTH = 4,
    parameter count_mode_e MODE  = MODE_BINARY
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             dir_up,
    input  logic             tc_gate,
    output logic             term_n
);

    localparam logic [WIDTH-1:0] TOP_BIN = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] TOP_DEC = WIDTH'(BCD_LAST);

    logic at_top;

    generate
        if (MODE == MODE_DECADE) begin : g_dec
            assign at_top = (cur == TOP_DEC) || bcd_odd_illegal(cur[3:0]);
        end else begin : g_bin
            assign at_top = (cur == TOP_BIN);
        end
    endgenerate

    assign term_n = ~(tc_gate & (dir_up ? at_top : (cur == '0)));

endmodule

// File: rtl/updn_counter.sv
module updn_counter
    import updn_pkg::*;
#(
    parameter int          WIDTH = 4,
    parameter count_mode_e MODE  = MODE_BINARY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pload_n,
    input  logic [WIDTH-1:0] d,
    input  logic             ena_p_n,
    input  logic             ena_t_n,
    input  logic             dir_up,
    output logic [WIDTH-1:0] cnt,
    output logic             term_n
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] DEC_NINE = WIDTH'(BCD_LAST);

    ctrl_t            ctrl;
    logic [WIDTH-1:0] nxt;

    updn_ctrl u_ctrl (
        .pload_n (pload_n),
        .ena_p_n (ena_p_n),
        .ena_t_n (ena_t_n),
        .dir_up  (dir_up),
        .ctrl    (ctrl)
    );

    updn_next #(.WIDTH(WIDTH), .MODE(MODE)) u_next (
        .cur (cnt),
        .d   (d),
        .op  (ctrl.op),
        .nxt (nxt)
    );

    updn_term #(.WIDTH(WIDTH), .MODE(MODE)) u_term (
        .cur     (cnt),
        .dir_up  (dir_up),
        .tc_gate (ctrl.tc_gate),
        .term_n  (term_n)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= nxt;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> cnt == '0); // R1

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        !pload_n |=> cnt == $past(d)); // R2

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (pload_n && (ena_p_n || ena_t_n)) |=> cnt == $past(cnt)); // R3

    AST_TC_GATED: assert property (@(posedge clk) disable iff (rst)
        ena_t_n |-> term_n); // R6

    generate
        if (MODE == MODE_DECADE) begin : g_chk_dec
            AST_DEC_DOWN_TO_NINE: assert property (@(posedge clk) disable iff (rst)
                (ctrl.op == OP_DOWN && cnt > DEC_NINE) |=> cnt == DEC_NINE); // R8
            AST_DEC_ODD_RECOVER: assert property (@(posedge clk) disable iff (rst)
                (ctrl.op == OP_UP && cnt > DEC_NINE && cnt[0]) |=> cnt <= DEC_NINE); // R8
            AST_DEC_ODD_TC: assert property (@(posedge clk) disable iff (rst)
                (!ena_t_n && dir_up && cnt > DEC_NINE && cnt[0]) |-> !term_n); // R7
            AST_DEC_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
                (ctrl.op == OP_UP && cnt == DEC_NINE) |=> cnt == '0); // R5
        end else begin : g_chk_bin
            AST_BIN_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
                (ctrl.op == OP_UP && cnt == ALL_ONES) |=> cnt == '0); // R5
            AST_BIN_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
                (ctrl.op == OP_DOWN && cnt == '0) |=> cnt == ALL_ONES); // R5
        end
    endgenerate

endmodule

// File: tb/sim_updn_counter.sv
module sim_updn_counter;
    import updn_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic       rst = 1'b1;
    logic       pload_n = 1'b1, ena_p_n = 1'b1, ena_t_n = 1'b1, dir_up = 1'b1;
    logic [3:0] d = '0;
    logic [3:0] cnt_dec, cnt_bin;
    logic       tn_dec, tn_bin;

    logic       c_load_n = 1'b1, c_enp_n = 1'b1, c_ent_n = 1'b1, c_up = 1'b1;
    logic [3:0] c_d_lo = '0, c_d_hi = '0;
    logic [3:0] c_lo, c_hi;
    logic       c_tn_lo, c_tn_hi;

    int n_chk = 0;
    int n_bad = 0;

    updn_counter #(.WIDTH(4), .MODE(MODE_DECADE)) u0 (
        .clk(clk), .rst(rst), .pload_n(pload_n), .d(d), .ena_p_n(ena_p_n),
        .ena_t_n(ena_t_n), .dir_up(dir_up), .cnt(cnt_dec), .term_n(tn_dec));

    updn_counter #(.WIDTH(4), .MODE(MODE_BINARY)) u_bin (
        .clk(clk), .rst(rst), .pload_n(pload_n), .d(d), .ena_p_n(ena_p_n),
        .ena_t_n(ena_t_n), .dir_up(dir_up), .cnt(cnt_bin), .term_n(tn_bin));

    updn_counter #(.WIDTH(4), .MODE(MODE_DECADE)) u_lo (
        .clk(clk), .rst(rst), .pload_n(c_load_n), .d(c_d_lo), .ena_p_n(c_enp_n),
        .ena_t_n(c_ent_n), .dir_up(c_up), .cnt(c_lo), .term_n(c_tn_lo));

    updn_counter #(.WIDTH(4), .MODE(MODE_DECADE)) u_hi (
        .clk(clk), .rst(rst), .pload_n(c_load_n), .d(c_d_hi), .ena_p_n(c_enp_n),
        .ena_t_n(c_tn_lo), .dir_up(c_up), .cnt(c_hi), .term_n(c_tn_hi));

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [3:0] v);
        pload_n = 1'b0; d = v;
        tick();
        pload_n = 1'b1;
    endtask

    task automatic t_reset();
        pload_n = 1'b0; d = 4'd5; ena_p_n = 1'b0; ena_t_n = 1'b0;
        rst = 1'b1;
        tick(); tick();
        check("R1 decade reset", cnt_dec, 0);
        check("R1 binary reset", cnt_bin, 0);
        rst = 1'b0; pload_n = 1'b1; ena_p_n = 1'b1; ena_t_n = 1'b1;
        tick();
    endtask

    task automatic t_load();
        ena_p_n = 1'b0; ena_t_n = 1'b0; dir_up = 1'b1;
        load(4'd7);
        check("R2 load with counting enabled", cnt_bin, 7);
        ena_p_n = 1'b1; ena_t_n = 1'b1; dir_up = 1'b0;
        load(4'd12);
        check("R2 load with enables off", cnt_bin, 12);
        check("R2 decade load illegal code", cnt_dec, 12);
    endtask

    task automatic t_hold();
        load(4'd4);
        ena_p_n = 1'b1; ena_t_n = 1'b0; dir_up = 1'b1;
        tick(); tick();
        check("R3 hold parallel enable high", cnt_bin, 4);
        ena_p_n = 1'b0; ena_t_n = 1'b1;
        tick();
        check("R3 hold trickle enable high", cnt_dec, 4);
        ena_p_n = 1'b1;
    endtask

    task automatic t_count();
        load(4'd3);
        ena_p_n = 1'b0; ena_t_n = 1'b0; dir_up = 1'b1;
        tick();
        check("R4 increment", cnt_bin, 4);
        dir_up = 1'b0;
        tick(); tick();
        check("R4 decrement", cnt_dec, 2);
        ena_p_n = 1'b1; ena_t_n = 1'b1;
    endtask

    task automatic t_wrap();
        load(4'd15);
        ena_p_n = 1'b0; ena_t_n = 1'b0; dir_up = 1'b1;
        tick();
        check("R5 binary up wrap", cnt_bin, 0);
        dir_up = 1'b0;
        tick();
        check("R5 binary down wrap", cnt_bin, 15);
        ena_p_n = 1'b1; ena_t_n = 1'b1;
        load(4'd9);
        ena_p_n = 1'b0; ena_t_n = 1'b0; dir_up = 1'b1;
        tick();
        check("R5 decade up wrap", cnt_dec, 0);
        dir_up = 1'b0;
        tick();
        check("R5 decade down wrap", cnt_dec, 9);
        ena_p_n = 1'b1; ena_t_n = 1'b1;
    endtask

    task automatic t_term();
        load(4'd15);
        ena_p_n = 1'b1; ena_t_n = 1'b0; dir_up = 1'b1; #1;
        check("R6 binary top, parallel enable high", tn_bin, 0);
        ena_p_n = 1'b0; #1;
        check("R6 binary top, parallel enable low", tn_bin, 0);
        ena_p_n = 1'b1; ena_t_n = 1'b1; #1;
        check("R6 trickle enable high blocks", tn_bin, 1);
        ena_t_n = 1'b0; dir_up = 1'b0; #1;
        check("R6 top while counting down", tn_bin, 1);
        load(4'd0); #1;
        check("R6 binary zero down", tn_bin, 0);
        check("R6 decade zero down", tn_dec, 0);
        load(4'd9); dir_up = 1'b1; #1;
        check("R6 decade nine up", tn_dec, 0);
        check("R6 binary nine up", tn_bin, 1);
        ena_t_n = 1'b1;
    endtask

    task automatic t_illegal();
        int up_exp[6] = '{11, 6, 13, 4, 15, 2};
        ena_p_n = 1'b1; ena_t_n = 1'b0; dir_up = 1'b1;
        for (int v = 10; v < 16; v++) begin
            load(4'(v)); #1;
            check($sformatf("R7 decade tc in state %0d", v), tn_dec, (v % 2 == 1) ? 0 : 1);
        end
        for (int v = 10; v < 16; v++) begin
            ena_p_n = 1'b1; ena_t_n = 1'b1;
            load(4'(v));
            ena_p_n = 1'b0; ena_t_n = 1'b0; dir_up = 1'b1;
            tick();
            check($sformatf("R8 up from %0d", v), cnt_dec, up_exp[v-10]);
            tick();
            check($sformatf("R8 legal two counts after %0d", v), (cnt_dec <= 9) ? 1 : 0, 1);
            ena_p_n = 1'b1; ena_t_n = 1'b1;
            load(4'(v));
            ena_p_n = 1'b0; ena_t_n = 1'b0; dir_up = 1'b0;
            tick();
            check($sformatf("R8 down from %0d", v), cnt_dec, 9);
        end
        ena_p_n = 1'b1; ena_t_n = 1'b1;
    endtask

    task automatic t_cascade();
        c_enp_n = 1'b1; c_ent_n = 1'b0; c_up = 1'b1;
        c_d_hi = 4'd1; c_d_lo = 4'd8; c_load_n = 1'b0;
        tick();
        c_load_n = 1'b1;
        check("R9 cascade load", c_hi * 10 + c_lo, 18);
        c_enp_n = 1'b0;
        tick();
        check("R9 cascade upper holds", c_hi * 10 + c_lo, 19);
        tick();
        check("R9 cascade carry up", c_hi * 10 + c_lo, 20);
        tick();
        check("R9 cascade after carry", c_hi * 10 + c_lo, 21);
        c_up = 1'b0;
        tick(); tick();
        check("R9 cascade borrow down", c_hi * 10 + c_lo, 19);
        c_enp_n = 1'b1;
        tick();
        check("R9 cascade shared parallel hold", c_hi * 10 + c_lo, 19);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_hold();
        t_count();
        t_wrap();
        t_term();
        t_illegal();
        t_cascade();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule